// File: doc/BRIEF.md
# Strobed Nibble Link for Strip Hit Vectors

This block moves a 16-bit strip hit vector from one chip to another over four data lanes and one strobe line. The transmitter side takes one vector every sample period (four system-clock cycles). It sends the vector as four 4-bit nibbles on consecutive system-clock cycles, with the least significant nibble first. The transmitter opens a sample period on the first system-clock edge at which acquisition is active, and opens a new one every fourth edge after that. On that first edge it also raises the strobe, together with the first nibble. The strobe then stays high for as long as acquisition lasts.

The receiver side does not use per-word framing or a header. It takes the nibble phase from the rising edge of the strobe alone. It counts nibbles modulo four from that edge and rebuilds each vector. It presents each vector on its output with a single-cycle valid pulse. If the strobe drops, any partly built word is thrown away, and the receiver waits for the next rising edge. The vector fed to the transmitter is typically the per-column OR of the pixel hits, one bit per column. Here it is just an input.

Both halves sit in one top module so that a link can be looped back. In a real system, the transmitter of one chip feeds the receiver of another.

Top module: `stripNibbleLink`

## Requirements
- R1: While rstN is low, txLanes reads 0, txStrobe reads 0, rxValid reads 0 and rxWord reads 0.
- R2: When acqEn was low at the last clock edge, txLanes reads 0 and txStrobe reads 0, whatever hitCols carries.
- R3: txStrobe goes high with the first nibble after acqEn is sampled high, and stays high on every edge at which acqEn stays high.
- R4: Counting edges with acqEn high from n=0, the vector on hitCols at edge 4m is captured. After edge 4m+b, txLanes carries bits 4b+3 down to 4b of that vector, for b = 0, 1, 2, 3, so bits 3..0 go first.
- R5: A change on hitCols at any edge other than 4m has no effect on the nibbles sent for the vector captured at edge 4m.
- R6: The receiver treats the nibble sampled at the edge where rxStrobe first reads high as bit field 3..0. The nibbles sampled at the next three edges fill 7..4, 11..8 and 15..12. rxWord and rxValid update on the edge that samples the fourth nibble.
- R7: While rxStrobe stays high, rxValid is a one-cycle pulse that repeats every fourth cycle. It is never high on two consecutive cycles.
- R8: A low on rxStrobe discards a partly received word. No valid pulse appears until four nibbles have been sampled after a new rising edge.
- R9: rxWord holds its value in every cycle in which rxValid is low.
- R10: With txLanes/txStrobe looped to rxLanes/rxStrobe, the vector captured at transmit edge 4m appears on rxWord with rxValid high after edge 4m+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, four times the sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| acqEn | input | 1 | Acquisition active; transmitter idles when low |
| hitCols | input | 16 | Strip hit vector, one bit per column |
| txLanes | output | 4 | Transmitted nibble |
| txStrobe | output | 1 | Transmit strobe, high for the whole acquisition |
| rxLanes | input | 4 | Received nibble |
| rxStrobe | input | 1 | Received strobe |
| rxWord | output | 16 | Rebuilt hit vector |
| rxValid | output | 1 | One-cycle pulse when rxWord carries a new vector |

## Verification
The bench sends walking-one, all-zero, all-one and arithmetic vectors through the loopback. It toggles hitCols in the three cycles between captures; a transmitter that captured on every cycle would then send corrupted upper nibbles. It stops and restarts acquisition to check that phase restarts at the new first edge rather than carrying on from the old count. On the receive side, it drives the strobe by hand to cut words short after one, two and three nibbles. A receiver that kept its nibble count across the gap would then emit a misaligned word, or emit too early. It also runs a long back-to-back stream in which each nibble position takes all sixteen values. This exposes nibble order swaps and valid pulses that are stretched or repeated.

// File: rtl/stripLinkPkg.sv
package stripLinkPkg;

  // Strobes from the transmit control to the transmit datapath.
  typedef struct packed {
    logic load;   // capture a new vector and send its low nibble
    logic shift;  // send the next held nibble
    logic idle;   // drive lanes to zero
  } txCtrlT;

  // Strobes from the receive control to the receive datapath.
  typedef struct packed {
    logic take;   // shift the sampled nibble into the accumulator
    logic emit;   // present the completed vector
    logic flush;  // drop any partial vector
  } rxCtrlT;

endpackage

// File: rtl/txCtrl.sv
module txCtrl
  import stripLinkPkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   acqEn,
  output txCtrlT ctl,
  output logic   strobeOut
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic [BW-1:0] beat;

  always_comb begin
    ctl.idle  = !acqEn;
    ctl.load  = acqEn && (beat == '0);
    ctl.shift = acqEn && (beat != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beat      <= '0;
      strobeOut <= 1'b0;
    end else if (!acqEn) begin
      beat      <= '0;
      strobeOut <= 1'b0;
    end else begin
      beat      <= (beat == LAST) ? '0 : beat + 1'b1;
      strobeOut <= 1'b1;
    end
  end
endmodule

// File: rtl/txPath.sv
module txPath
  import stripLinkPkg::*;
#(
  parameter int LANES = 4,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  txCtrlT                   ctl,
  input  logic [LANES*BEATS-1:0]   word,
  output logic [LANES-1:0]         laneOut
);
  localparam int WORD_W = LANES * BEATS;

  logic [WORD_W-1:0] hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hold    <= '0;
      laneOut <= '0;
    end else if (ctl.idle) begin
      hold    <= '0;
      laneOut <= '0;
    end else if (ctl.load) begin
      laneOut <= word[LANES-1:0];
      hold    <= word >> LANES;
    end else if (ctl.shift) begin
      laneOut <= hold[LANES-1:0];
      hold    <= hold >> LANES;
    end
  end
endmodule

// File: rtl/rxCtrl.sv
module rxCtrl
  import stripLinkPkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   strobeIn,
  output rxCtrlT ctl
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic          prevStb;
  logic [BW-1:0] nextIdx;
  logic          rise;

  assign rise = strobeIn && !prevStb;

  always_comb begin
    ctl.take  = strobeIn;
    ctl.flush = !strobeIn;
    ctl.emit  = strobeIn && !rise && (nextIdx == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStb <= 1'b0;
      nextIdx <= '0;
    end else begin
      prevStb <= strobeIn;
      if (!strobeIn)               nextIdx <= '0;
      else if (rise)               nextIdx <= BW'(1);
      else if (nextIdx == LAST)    nextIdx <= '0;
      else                         nextIdx <= nextIdx + 1'b1;
    end
  end
endmodule

// File: rtl/rxPath.sv
module rxPath
  import stripLinkPkg::*;
#(
  parameter int LANES = 4,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxCtrlT                   ctl,
  input  logic [LANES-1:0]         laneIn,
  output logic [LANES*BEATS-1:0]   wordOut,
  output logic                     validOut
);
  localparam int WORD_W = LANES * BEATS;

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] accNext;

  assign accNext = {laneIn, acc[WORD_W-1:LANES]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      wordOut  <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= ctl.emit;
      if (ctl.flush)     acc <= '0;
      else if (ctl.take) acc <= accNext;
      if (ctl.emit)      wordOut <= accNext;
    end
  end
endmodule

// File: rtl/stripNibbleLink.sv
module stripNibbleLink
  import stripLinkPkg::*;
#(
  parameter int LANES = 4,
  parameter int BEATS = 4,
  localparam int WORD_W = LANES * BEATS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqEn,
  input  logic [WORD_W-1:0] hitCols,
  output logic [LANES-1:0]  txLanes,
  output logic              txStrobe,
  input  logic [LANES-1:0]  rxLanes,
  input  logic              rxStrobe,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  txCtrlT txCtl;
  rxCtrlT rxCtl;

  txCtrl #(.BEATS(BEATS)) txCtrl_i (
    .clk(clk), .rstN(rstN), .acqEn(acqEn), .ctl(txCtl), .strobeOut(txStrobe)
  );

  txPath #(.LANES(LANES), .BEATS(BEATS)) txPath_i (
    .clk(clk), .rstN(rstN), .ctl(txCtl), .word(hitCols), .laneOut(txLanes)
  );

  rxCtrl #(.BEATS(BEATS)) rxCtrl_i (
    .clk(clk), .rstN(rstN), .strobeIn(rxStrobe), .ctl(rxCtl)
  );

  rxPath #(.LANES(LANES), .BEATS(BEATS)) rxPath_i (
    .clk(clk), .rstN(rstN), .ctl(rxCtl), .laneIn(rxLanes),
    .wordOut(rxWord), .validOut(rxValid)
  );
endmodule

// File: rtl/stripNibbleLinkChk.sv
module stripNibbleLinkChk #(
  parameter int LANES = 4,
  parameter int BEATS = 4,
  localparam int WORD_W = LANES * BEATS
) (
  input logic              clk,
  input logic              rstN,
  input logic              acqEn,
  input logic [WORD_W-1:0] hitCols,
  input logic [LANES-1:0]  txLanes,
  input logic              txStrobe,
  input logic [LANES-1:0]  rxLanes,
  input logic              rxStrobe,
  input logic [WORD_W-1:0] rxWord,
  input logic              rxValid
);
  // R2: an idle cycle leaves the lanes and strobe quiet
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !acqEn |=> (txLanes == '0 && !txStrobe));

  // R3: strobe is high after every edge with acquisition active
  a_r3_strobe_held: assert property (@(posedge clk) disable iff (!rstN)
    acqEn |=> txStrobe);

  // R7: valid never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8: a low strobe blocks the next valid
  a_r8_low_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !rxStrobe |=> !rxValid);

  // R6/R8: the rising-edge nibble starts a word, so no valid follows it
  a_r6_rise_starts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxStrobe) |=> !rxValid);

  // R9: the output word only moves with valid
  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord));
endmodule

bind stripNibbleLink stripNibbleLinkChk #(.LANES(LANES), .BEATS(BEATS)) chk_i (
  .clk(clk), .rstN(rstN), .acqEn(acqEn), .hitCols(hitCols),
  .txLanes(txLanes), .txStrobe(txStrobe), .rxLanes(rxLanes),
  .rxStrobe(rxStrobe), .rxWord(rxWord), .rxValid(rxValid)
);

// File: tb/stripNibbleLink_tb_top.sv
module stripNibbleLink_tb_top;
  localparam int LANES  = 4;
  localparam int BEATS  = 4;
  localparam int WORD_W = 16;
  localparam int NWORDS = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic              acqEn;
  logic [WORD_W-1:0] hitCols;
  logic [LANES-1:0]  txLanes, rxLanes, manLanes;
  logic              txStrobe, rxStrobe, manStb, manual;
  logic [WORD_W-1:0] rxWord;
  logic              rxValid;

  assign rxLanes  = manual ? manLanes : txLanes;
  assign rxStrobe = manual ? manStb   : txStrobe;

  stripNibbleLink #(.LANES(LANES), .BEATS(BEATS)) dut_i (
    .clk(clk), .rstN(rstN), .acqEn(acqEn), .hitCols(hitCols),
    .txLanes(txLanes), .txStrobe(txStrobe), .rxLanes(rxLanes),
    .rxStrobe(rxStrobe), .rxWord(rxWord), .rxValid(rxValid)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Pattern m: walking ones, then all-zero, all-one, then arithmetic mixes.
  function automatic logic [WORD_W-1:0] patt(int m);
    if (m < 16)       return WORD_W'(1) << m;
    else if (m == 16) return '0;
    else if (m == 17) return '1;
    else              return WORD_W'((m * 40503) ^ (m << 7) ^ 16'h5A3C);
  endfunction

  // Transmit run with loopback: words base..base+cnt-1.
  task automatic txRun(int base, int cnt);
    for (int n = 0; n < 4 * cnt; n++) begin
      logic [WORD_W-1:0] w;
      logic              expV;
      @(negedge clk);
      acqEn   = 1'b1;
      w       = patt(base + n / 4);
      hitCols = (n % 4 == 0) ? w : (~w ^ WORD_W'(n * 911));
      @(posedge clk);
      #2;
      chk("R3", "txStrobe", 32'(txStrobe), 32'd1);
      chk((n % 4 == 0) ? "R4" : "R5", "txLanes", 32'(txLanes), 32'(w[(n % 4) * 4 +: 4]));
      expV = (n >= 4) && (n % 4 == 0);
      chk("R7", "rxValid loop", 32'(rxValid), 32'(expV));
      if (expV) chk("R10", "rxWord loop", 32'(rxWord), 32'(patt(base + n / 4 - 1)));
    end
    @(negedge clk);
    acqEn   = 1'b0;
    hitCols = 16'hFFFF;
    @(posedge clk);
    #2;
    chk("R2", "txLanes idle", 32'(txLanes), 32'd0);
    chk("R2", "txStrobe idle", 32'(txStrobe), 32'd0);
    chk("R10", "last rxValid", 32'(rxValid), 32'd1);
    chk("R10", "last rxWord", 32'(rxWord), 32'(patt(base + cnt - 1)));
    @(negedge clk);
    @(posedge clk);
    #2;
    chk("R7", "rxValid after stop", 32'(rxValid), 32'd0);
    chk("R9", "rxWord held", 32'(rxWord), 32'(patt(base + cnt - 1)));
  endtask

  task automatic cyc(logic stb, logic [LANES-1:0] nib);
    @(negedge clk);
    manStb   = stb;
    manLanes = nib;
    @(posedge clk);
    #2;
  endtask

  initial begin
    logic [WORD_W-1:0] x;
    rstN = 1'b0; acqEn = 1'b0; hitCols = 16'hA5A5;
    manual = 1'b0; manStb = 1'b0; manLanes = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "txLanes reset", 32'(txLanes), 32'd0);
    chk("R1", "txStrobe reset", 32'(txStrobe), 32'd0);
    chk("R1", "rxValid reset", 32'(rxValid), 32'd0);
    chk("R1", "rxWord reset", 32'(rxWord), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      hitCols = 16'h3C00 ^ 16'(i * 257);
      @(posedge clk);
      #2;
      chk("R2", "txLanes quiet", 32'(txLanes), 32'd0);
      chk("R2", "txStrobe quiet", 32'(txStrobe), 32'd0);
    end

    txRun(0, NWORDS);
    repeat (2) @(negedge clk);
    txRun(NWORDS, 3);   // restart: phase from the new first edge

    // Receive side driven by hand
    manual = 1'b1;
    cyc(1'b0, 4'h0);
    // R8: cut after one, two and three nibbles
    for (int cut = 1; cut <= 3; cut++) begin
      for (int b = 0; b < cut; b++) begin
        cyc(1'b1, 4'(b + 7));
        chk("R8", "partial no valid", 32'(rxValid), 32'd0);
      end
      cyc(1'b0, 4'hF);
      chk("R8", "gap no valid", 32'(rxValid), 32'd0);
      x = 16'hC3E1 ^ 16'(cut * 4369);
      for (int b = 0; b < 4; b++) begin
        cyc(1'b1, x[b * 4 +: 4]);
        chk((b == 3) ? "R6" : "R8", "rxValid after rise", 32'(rxValid), 32'(b == 3));
        if (b == 3) chk("R6", "rxWord after rise", 32'(rxWord), 32'(x));
      end
      cyc(1'b0, 4'h5);
      chk("R9", "word held after drop", 32'(rxWord), 32'(x));
      chk("R8", "no valid after drop", 32'(rxValid), 32'd0);
    end

    // R7 / R6: back-to-back stream, each nibble position takes all values
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 4; b++) begin
        logic [WORD_W-1:0] prevW;
        prevW = rxWord;
        cyc(1'b1, 4'((k + 5 * b) & 15));
        chk("R7", "stream rxValid", 32'(rxValid), 32'(b == 3));
        if (b == 3) begin
          x = {4'((k + 15) & 15), 4'((k + 10) & 15), 4'((k + 5) & 15), 4'(k & 15)};
          chk("R6", "stream rxWord", 32'(rxWord), 32'(x));
        end else if (k > 0 || b > 0) begin
          chk("R9", "stream hold", 32'(rxWord), 32'(prevW));
        end
      end
    end
    cyc(1'b0, 4'h0);
    chk("R8", "final low", 32'(rxValid), 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule